// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block generates the two timing strobes of an 8-bit controller's multiplexed external memory bus. The first is the address latch enable (`ale`, active high), which tells an external latch to capture the low address byte. The second is the program store enable (`psen_n`, active low), the read strobe for external program memory. The oscillator clock drives a twelve-count machine cycle. That cycle is split into two halves of six counts. Each half carries one latch pulse near its start and one read strobe in its later counts.

A program-source select pin is captured while reset is held and is ignored afterwards. When it was captured high, fetches below 32768 come from internal memory. When it was captured low, every fetch goes to the external bus. A per-machine-cycle data-move request turns the cycle into an external data access: it keeps the first latch pulse, drops the second, and skips both program reads. A software-written latch-quiet bit silences the latch strobe while code runs internally. The bit gives way to data moves, to fetches beyond internal space and to an external program source. Idle and power-down requests freeze the sequence and hold fixed strobe levels.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: Outside reset and low-power modes, machine-cycle count 0 is the first clock after reset release or low-power exit. The count then runs 0..11 and wraps. `ale` is high at counts 0, 1, 6 and 7 unless a later rule suppresses it.
- R2: `fetch_ext` is 1 when the captured program source is external or when `fetch_addr` >= 32768, and 0 otherwise. `psen_n` is low at counts 3, 4, 5, 9, 10 and 11 when `fetch_ext` is 1 and the cycle is not a data move. It is high at all other times.
- R3: `data_move` is sampled at count 0 and marks the whole machine cycle as a data move. In such a cycle `ale` pulses only at counts 0 and 1, and `psen_n` stays high.
- R4: The latch-quiet bit is written from `quiet_wdata` on a clock edge where `quiet_we` is 1. It takes effect on the next clock and is cleared by reset.
- R5: With the quiet bit set and `fetch_ext` = 0, `ale` stays low, except for the count 0 and 1 pulse of a data-move cycle.
- R6: With the quiet bit set and `fetch_addr` >= 32768, `ale` and `psen_n` follow the same pattern as with the bit clear.
- R7: `ext_src_sel` is captured on every clock while `rst_n` is low and is ignored afterwards, with 1 selecting the internal source. When the captured source is external, the quiet bit has no effect on `ale`.
- R8: While `pdown_req` is 1, `ale` is low and `psen_n` is high. While only `idle_req` is 1, both `ale` and `psen_n` are high. In both modes the count holds at 0, and any pending data move is dropped.
- R9: While `rst_n` is low, `ale` is low and `psen_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_src_sel | input | 1 | Program source select, captured during reset (1 = internal allowed) |
| fetch_addr | input | 16 | Address of the current program fetch |
| data_move | input | 1 | Marks the machine cycle starting now as an external data move |
| idle_req | input | 1 | Idle mode request |
| pdown_req | input | 1 | Power-down request, overrides idle |
| quiet_we | input | 1 | Write strobe for the latch-quiet bit |
| quiet_wdata | input | 1 | Value written to the latch-quiet bit |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |
| fetch_ext | output | 1 | Current fetch goes to external memory |

## Verification
A counter that has slipped a phase shows as latch pulses and read strobes moved off counts 0/1/6/7 and 3-5/9-11. The bench checks twelve-count windows, so the slip appears within one machine cycle of low-power exit. A stale data-move flag shows in the same cycle as a missing second latch pulse or missing reads. A quiet bit that survives reset, or a source flag recaptured after reset, changes `ale` or `fetch_ext` on the first machine cycle after reset release.

// File: rtl/esq_pkg.sv
package esq_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_IDLE = 2'd1,
        MODE_DOWN = 2'd2,
        MODE_RST  = 2'd3
    } seq_mode_e;

    typedef struct packed {
        logic quiet;
        logic mv;
    } ctl_state_t;

endpackage

// File: rtl/esq_phase_ctr.sv
module esq_phase_ctr #(
    parameter int CYC_LEN = 12,
    localparam int CW = $clog2(CYC_LEN)
) (
    input  logic          clk,
    input  logic          hold,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (hold) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(CYC_LEN - 1)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/esq_src_sel.sv
module esq_src_sel #(
    parameter int ADDR_W   = 16,
    parameter int INT_SIZE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_pin,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ext
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(INT_SIZE);

    logic ext_only_d, ext_only_q;

    always_comb begin
        ext_only_d = rst_n ? ext_only_q : ~src_pin;
    end

    always_ff @(posedge clk) begin
        ext_only_q <= ext_only_d;
    end

    assign fetch_ext = ext_only_q | ({1'b0, fetch_addr} >= LIMIT);
endmodule

// File: rtl/esq_strobe_gen.sv
module esq_strobe_gen
    import esq_pkg::*;
#(
    parameter int CYC_LEN    = 12,
    parameter int ALE_W      = 2,
    parameter int PSEN_START = 3,
    localparam int CW   = $clog2(CYC_LEN),
    localparam int HALF = CYC_LEN / 2
) (
    input  logic [CW-1:0] cnt,
    input  seq_mode_e     mode,
    input  logic          fetch_ext,
    input  logic          mv_eff,
    input  logic          quiet,
    output logic          ale,
    output logic          psen_n
);
    logic          second;
    logic [CW-1:0] pos;
    logic          ale_slot;
    logic          psen_slot;

    always_comb begin
        second    = cnt >= CW'(HALF);
        pos       = second ? cnt - CW'(HALF) : cnt;
        ale_slot  = pos < CW'(ALE_W);
        psen_slot = pos >= CW'(PSEN_START);
        unique case (mode)
            MODE_RUN: begin
                ale    = ale_slot && !(mv_eff && second)
                         && (!quiet || fetch_ext || mv_eff);
                psen_n = !(psen_slot && fetch_ext && !mv_eff);
            end
            MODE_IDLE: begin
                ale    = 1'b1;
                psen_n = 1'b1;
            end
            default: begin
                ale    = 1'b0;
                psen_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq
    import esq_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int INT_SIZE   = 32768,
    parameter int CYC_LEN    = 12,
    parameter int ALE_W      = 2,
    parameter int PSEN_START = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_src_sel,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              data_move,
    input  logic              idle_req,
    input  logic              pdown_req,
    input  logic              quiet_we,
    input  logic              quiet_wdata,
    output logic              ale,
    output logic              psen_n,
    output logic              fetch_ext
);
    localparam int CW = $clog2(CYC_LEN);

    ctl_state_t    ctl_d, ctl_q;
    seq_mode_e     mode;
    logic [CW-1:0] cnt;
    logic          mv_eff;
    logic          hold;

    always_comb begin
        if (!rst_n)         mode = MODE_RST;
        else if (pdown_req) mode = MODE_DOWN;
        else if (idle_req)  mode = MODE_IDLE;
        else                mode = MODE_RUN;
        hold   = mode != MODE_RUN;
        mv_eff = (cnt == '0) ? data_move : ctl_q.mv;

        ctl_d       = ctl_q;
        ctl_d.quiet = quiet_we ? quiet_wdata : ctl_q.quiet;
        ctl_d.mv    = hold ? 1'b0 : mv_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    esq_phase_ctr #(
        .CYC_LEN(CYC_LEN)
    ) ctr_i (
        .clk (clk),
        .hold(hold),
        .cnt (cnt)
    );

    esq_src_sel #(
        .ADDR_W  (ADDR_W),
        .INT_SIZE(INT_SIZE)
    ) src_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pin   (ext_src_sel),
        .fetch_addr(fetch_addr),
        .fetch_ext (fetch_ext)
    );

    esq_strobe_gen #(
        .CYC_LEN   (CYC_LEN),
        .ALE_W     (ALE_W),
        .PSEN_START(PSEN_START)
    ) gen_i (
        .cnt      (cnt),
        .mode     (mode),
        .fetch_ext(fetch_ext),
        .mv_eff   (mv_eff),
        .quiet    (ctl_q.quiet),
        .ale      (ale),
        .psen_n   (psen_n)
    );
endmodule

// File: rtl/esq_chk.sv
module esq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              idle_req,
    input logic              pdown_req,
    input logic              ale,
    input logic              psen_n,
    input logic              fetch_ext
);
    // R2
    psen_only_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !psen_n |-> fetch_ext);

    // R8
    pdown_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdown_req |-> (!ale && psen_n));

    // R8
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && !pdown_req) |-> (ale && psen_n));

    // R7
    src_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(fetch_addr)) |-> $stable(fetch_ext));

    // R9
    always_comb begin
        if (!rst_n) begin
            reset_levels_chk: assert (!ale && psen_n);
        end
    end
endmodule

bind ext_bus_strobe_seq esq_chk #(
    .ADDR_W(ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_addr(fetch_addr),
    .idle_req  (idle_req),
    .pdown_req (pdown_req),
    .ale       (ale),
    .psen_n    (psen_n),
    .fetch_ext (fetch_ext)
);

// File: tb/ext_bus_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module ext_bus_strobe_seq_tb_top;

    typedef struct packed {
        logic [15:0] addr;
        logic        quiet;
        logic        mv;
        logic        idle;
        logic        pd;
        logic        pin;
        logic        fe;
        logic [11:0] ale_m;
        logic [11:0] psen_m;
        logic [3:0]  req;
    } vec_t;

    localparam int NV   = 20;
    localparam int SEGB = 15;

    // masks: bit k = level at machine-cycle count k
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h0C3, 12'hFFF, 4'd1}, // R1
        '{16'h9000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0C3, 12'h1C7, 4'd2}, // R2
        '{16'h7FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h0C3, 12'hFFF, 4'd2}, // R2
        '{16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0C3, 12'h1C7, 4'd2}, // R2
        '{16'h9000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 12'h003, 12'hFFF, 4'd3}, // R3
        '{16'h0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'h003, 12'hFFF, 4'd3}, // R3
        '{16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'hFFF, 4'd5}, // R5
        '{16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0C3, 12'h1C7, 4'd6}, // R6
        '{16'h0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 12'h003, 12'hFFF, 4'd5}, // R5
        '{16'h0100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 12'hFFF, 12'hFFF, 4'd8}, // R8
        '{16'h0100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000, 12'hFFF, 4'd8}, // R8
        '{16'h9000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 12'hFFF, 4'd8}, // R8
        '{16'h9000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 12'hFFF, 12'hFFF, 4'd8}, // R8
        '{16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h0C3, 12'hFFF, 4'd1}, // R1
        '{16'h9000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0C3, 12'h1C7, 4'd1}, // R1
        '{16'h0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0C3, 12'h1C7, 4'd7}, // R7
        '{16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 12'h0C3, 12'h1C7, 4'd7}, // R7
        '{16'h0100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 12'h003, 12'hFFF, 4'd3}, // R3
        '{16'h0100, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 12'hFFF, 12'hFFF, 4'd8}, // R8
        '{16'h0100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h0C3, 12'hFFF, 4'd4}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_src_sel = 1'b1;
    logic [15:0] fetch_addr = '0;
    logic        data_move = 1'b0;
    logic        idle_req = 1'b0;
    logic        pdown_req = 1'b0;
    logic        quiet_we = 1'b0;
    logic        quiet_wdata = 1'b0;
    logic        ale, psen_n, fetch_ext;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    ext_bus_strobe_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_src_sel(ext_src_sel),
        .fetch_addr (fetch_addr),
        .data_move  (data_move),
        .idle_req   (idle_req),
        .pdown_req  (pdown_req),
        .quiet_we   (quiet_we),
        .quiet_wdata(quiet_wdata),
        .ale        (ale),
        .psen_n     (psen_n),
        .fetch_ext  (fetch_ext)
    );

    task automatic check_reset();
        @(negedge clk);
        #1;
        n_chk++;
        if (!(ale == 1'b0 && psen_n == 1'b1)) begin
            n_fail++;
            $display("FAIL R9 reset levels: ale=%b psen_n=%b expected ale=0 psen_n=1",
                     ale, psen_n);
        end
    endtask

    task automatic run_vec(input int i, input bit wr, input bit nxt_quiet);
        logic [11:0] ale_g, psen_g;
        logic [11:0] fe_g, fe_e;
        vec_t v;
        v = VECS[i];
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            fetch_addr  = v.addr;
            data_move   = v.mv;
            idle_req    = v.idle;
            pdown_req   = v.pd;
            ext_src_sel = v.pin;
            quiet_we    = wr;
            quiet_wdata = (k == 11) ? nxt_quiet : v.quiet;
            #1;
            ale_g[k]  = ale;
            psen_g[k] = psen_n;
            fe_g[k]   = fetch_ext;
        end
        fe_e = {12{v.fe}};
        n_chk++;
        if (ale_g !== v.ale_m || psen_g !== v.psen_m || fe_g !== fe_e) begin
            n_fail++;
            $display("FAIL R%0d vec %0d: ale=%h psen_n=%h fe=%h expected ale=%h psen_n=%h fe=%h",
                     v.req, i, ale_g, psen_g, fe_g, v.ale_m, v.psen_m, fe_e);
        end
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run still active, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // Segment A: source captured internal (R9 reset levels first)
        rst_n = 1'b0;
        ext_src_sel = 1'b1;
        repeat (3) @(posedge clk);
        check_reset();
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < SEGB; i++) begin
            run_vec(i, 1'b1, (i + 1 < NV) ? VECS[i+1].quiet : 1'b0);
        end

        // Segment B: source captured external, pin raised afterwards (R7)
        @(negedge clk);
        rst_n = 1'b0;
        ext_src_sel = 1'b0;
        quiet_we = 1'b0;
        idle_req = 1'b0;
        pdown_req = 1'b0;
        data_move = 1'b0;
        repeat (3) @(posedge clk);
        check_reset();
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = SEGB; i < NV - 1; i++) begin
            run_vec(i, 1'b1, VECS[i+1].quiet);
        end

        // R4: quiet bit was set before this reset; reset must clear it
        @(negedge clk);
        quiet_we = 1'b0;
        rst_n = 1'b0;
        ext_src_sel = 1'b1;
        idle_req = 1'b0;
        repeat (3) @(posedge clk);
        @(posedge clk);
        #1 rst_n = 1'b1;
        run_vec(NV - 1, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule